// File: doc/BRIEF.md
# Parallel Host Register Bus Port

This block is the slave side of an 8-bit parallel host bus. It lets an external microcontroller read and write registers that sit behind a simple internal access port. A static mode input picks the bus style. In multiplexed style, the address and the data share one set of eight lines, and an address-latch input marks when those lines carry the address. In split style, the address arrives on its own eight lines and the shared lines carry data only.

Every host-side input is passed through a two-flop synchronizer onto the system clock. This includes chip select, latch, both strobes, and both sets of lines. Strobe edges are detected after the synchronizers and are turned into single internal requests. Each request is held on the internal port until the register side answers with a done pulse. The done pulse may arrive in the same cycle as the request or any number of cycles later.

While a request is outstanding, the ready output is driven low so that the host stretches its cycle. At all other times the ready output floats. The pad cells are outside the block: the block presents the data bus as separate in, out and output-enable signals, and presents ready as a single "drive low" request.

Top module: `hostbus_port`

## Requirements
- R1: While `cs_n` is high, falling or rising edges of `rd_n`/`wr_n` and pulses on `ale` cause no internal access and no change to the latched address. `dq_oe` stays low and `rdy_low` is not requested on behalf of such a strobe.
- R2: With `mux_mode` = 1, the address used by an access is the value present on `dq_in` while `ale` was last high with `cs_n` low.
- R3: With `mux_mode` = 0 and an `ale` pulse (with `cs_n` low) seen before the strobe, the access uses the value that `addr_in` held during that pulse, even if `addr_in` changes before the strobe. In this mode `dq_in` carries only write data.
- R4: With `mux_mode` = 0 and no `ale` pulse since the previous strobe, the access uses the value on `addr_in` at the falling edge of the strobe.
- R5: Write data is taken from `dq_in` while `wr_n` is low and `cs_n` is low. The value present just before `wr_n` rises is committed as exactly one internal write request, issued after the rising edge has passed the two-flop synchronizer.
- R6: `dq_oe` is high exactly while `cs_n` and `rd_n` are both low. Once `rdy_low` has been released during a read strobe, `dq_out` holds the content of the addressed register.
- R7: `rdy_low` is high from the falling edge of a selected `rd_n` until that read's data is in the output buffer. It is also high from the detection of a write commit until the register side reports done. Otherwise it is low, meaning the pin floats.
- R8: `reg_req` stays high, with `reg_addr`, `reg_we` and `reg_wdata` unchanged, until `reg_done` is seen high. A done in the first request cycle is accepted, as is a done after any wait.
- R9: If `rd_n` and `wr_n` are low together while selected, the read is serviced and the write is discarded. The addressed register keeps its old value.
- R10: Directly after reset, `reg_req`, `dq_oe` and `rdy_low` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mux_mode | input | 1 | 1 = shared address/data lines, 0 = split address lines (static) |
| cs_n | input | 1 | Chip select, active low |
| ale | input | 1 | Address latch enable, active high |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| addr_in | input | 8 | Dedicated address lines (split mode) |
| dq_in | input | 8 | Shared lines, input side |
| dq_out | output | 8 | Shared lines, read data output |
| dq_oe | output | 1 | Output enable for the shared lines |
| rdy_low | output | 1 | Request to drive the ready pin low (otherwise it floats) |
| reg_req | output | 1 | Internal access request |
| reg_we | output | 1 | Internal access is a write |
| reg_addr | output | 8 | Internal access address |
| reg_wdata | output | 8 | Internal write data |
| reg_rdata | input | 8 | Internal read data, valid with `reg_done` |
| reg_done | input | 1 | Register side has finished the access |

## Verification
Most faults in this block surface at the ports within a few cycles. A pending flag that never clears, or an engine stuck in its access state, leaves `rdy_low` high, and the host's wait for ready then times out. A wrong latched address, a lost "latch seen" flag, or a failed write kill does not show at once. It appears as a wrong value on `dq_out` at the next read-back of the affected register. For that reason every scenario ends by reading back the register it aimed at, and a register it must not have touched. The internal port is exercised with a done latency that varies from zero to seven cycles.

// File: rtl/hb_pkg.sv
// Shared definitions for the host bus port.
// Assumes an 8-bit host bus by default; all widths are overridable.
package hb_pkg;
    localparam int HB_AW     = 8;
    localparam int HB_DW     = 8;
    localparam int HB_STAGES = 2;

    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_BUSY = 1'b1
    } eng_state_t;
endpackage

// File: rtl/hb_sync.sv
// Multi-bit flop chain that brings asynchronous host pins onto clk.
// Assumes the bundled data lines are stable whenever the strobes that
// qualify them change, so per-bit skew is harmless.
module hb_sync #(
    parameter int         W      = 4,
    parameter int         STAGES = 2,
    parameter logic [W-1:0] RSTV = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // first capture stage
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= RSTV;
                else        stg[i] <= d;
            end
        end else begin : g_next
            // further settling stages
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= RSTV;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hb_front.sv
// Strobe decoding: edge detection gated by chip select, address
// latching for both bus styles, write data capture and read priority.
// Assumes synchronized inputs; events are single-cycle pulses.
module hb_front #(
    parameter int AW = hb_pkg::HB_AW,
    parameter int DW = hb_pkg::HB_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mux_mode,
    input  logic          s_cs_n,
    input  logic          s_ale,
    input  logic          s_wr_n,
    input  logic          s_rd_n,
    input  logic [DW-1:0] s_dq,
    input  logic [AW-1:0] s_addr,
    output logic          rd_evt,
    output logic          wr_evt,
    output logic [AW-1:0] fall_addr,
    output logic [AW-1:0] acc_addr,
    output logic [DW-1:0] wdata
);
    logic          sel;
    logic          wr_q, rd_q;
    logic          rd_fall, wr_fall, wr_rise;
    logic          ale_seen;
    logic          wr_kill;
    logic [AW-1:0] addr_lat;

    assign sel     = !s_cs_n;
    assign rd_fall = sel && !s_rd_n && rd_q;
    assign wr_fall = sel && !s_wr_n && wr_q;
    assign wr_rise = sel && s_wr_n && !wr_q;

    // address chosen at a strobe's falling edge
    always_comb begin
        if (mux_mode || ale_seen) fall_addr = addr_lat;
        else                      fall_addr = s_addr;
    end

    assign rd_evt = rd_fall;
    assign wr_evt = wr_rise && !wr_kill;

    // previous strobe levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= 1'b1;
            rd_q <= 1'b1;
        end else begin
            wr_q <= s_wr_n;
            rd_q <= s_rd_n;
        end
    end

    // address latch and the flag marking a latch since the last strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_lat <= '0;
            ale_seen <= 1'b0;
        end else if (sel && s_ale) begin
            addr_lat <= mux_mode ? AW'(s_dq) : s_addr;
            ale_seen <= 1'b1;
        end else if (rd_fall || wr_fall) begin
            ale_seen <= 1'b0;
        end
    end

    // access address frozen at the strobe's falling edge
    always_ff @(posedge clk) begin
        if (!rst_n)                  acc_addr <= '0;
        else if (rd_fall || wr_fall) acc_addr <= fall_addr;
    end

    // write data follows the lines while the write strobe is low
    always_ff @(posedge clk) begin
        if (!rst_n)                wdata <= '0;
        else if (sel && !s_wr_n)   wdata <= s_dq;
    end

    // a read overlapping a write cancels that write
    always_ff @(posedge clk) begin
        if (!rst_n)                       wr_kill <= 1'b0;
        else if (s_wr_n)                  wr_kill <= 1'b0;
        else if (sel && !s_rd_n)          wr_kill <= 1'b1;
    end

    // R9
    rd_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !s_wr_n && !s_rd_n) |=> !wr_evt);

    // R1
    idle_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_cs_n |-> (!rd_evt && !wr_evt));
endmodule

// File: rtl/hb_engine.sv
// Internal access sequencer: queues one read and one write, issues them
// on the request/done port (read first) and buffers read data.
// Assumes the host waits for ready before starting another strobe.
module hb_engine #(
    parameter int AW = hb_pkg::HB_AW,
    parameter int DW = hb_pkg::HB_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_evt,
    input  logic          wr_evt,
    input  logic [AW-1:0] rd_addr_in,
    input  logic [AW-1:0] wr_addr_in,
    input  logic [DW-1:0] wr_data_in,
    output logic          reg_req,
    output logic          reg_we,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    input  logic [DW-1:0] reg_rdata,
    input  logic          reg_done,
    output logic [DW-1:0] rd_buf,
    output logic          rd_cmp,
    output logic          busy
);
    import hb_pkg::*;

    eng_state_t    state;
    logic          rd_pend, wr_pend;
    logic [AW-1:0] rd_pa, wr_pa;
    logic [DW-1:0] wr_pd;
    logic          start_rd, start_wr;

    assign start_rd = (state == ENG_IDLE) && rd_pend;
    assign start_wr = (state == ENG_IDLE) && !rd_pend && wr_pend;
    assign reg_req  = (state == ENG_BUSY);
    assign busy     = rd_pend || wr_pend || reg_req;

    // pending requests recorded from strobe events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend <= 1'b0;
            wr_pend <= 1'b0;
            rd_pa   <= '0;
            wr_pa   <= '0;
            wr_pd   <= '0;
        end else begin
            if (start_rd) rd_pend <= 1'b0;
            if (start_wr) wr_pend <= 1'b0;
            if (rd_evt) begin
                rd_pend <= 1'b1;
                rd_pa   <= rd_addr_in;
            end
            if (wr_evt) begin
                wr_pend <= 1'b1;
                wr_pa   <= wr_addr_in;
                wr_pd   <= wr_data_in;
            end
        end
    end

    // access state and the request fields held on the port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ENG_IDLE;
            reg_we    <= 1'b0;
            reg_addr  <= '0;
            reg_wdata <= '0;
        end else if (start_rd) begin
            state    <= ENG_BUSY;
            reg_we   <= 1'b0;
            reg_addr <= rd_pa;
        end else if (start_wr) begin
            state     <= ENG_BUSY;
            reg_we    <= 1'b1;
            reg_addr  <= wr_pa;
            reg_wdata <= wr_pd;
        end else if (reg_req && reg_done) begin
            state <= ENG_IDLE;
        end
    end

    // read data buffer and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_buf <= '0;
            rd_cmp <= 1'b0;
        end else begin
            rd_cmp <= reg_req && reg_done && !reg_we;
            if (reg_req && reg_done && !reg_we) rd_buf <= reg_rdata;
        end
    end

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_done) |=> reg_req);

    // R8
    req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_done) |=> ($stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata)));

    // R6
    rd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_done && !reg_we) |=> (rd_buf == $past(reg_rdata)));
endmodule

// File: rtl/hostbus_port.sv
// Top of the host bus port: synchronizes host pins, decodes strobes,
// runs internal accesses and produces data-bus and ready controls.
// Assumes external pads: dq_oe enables dq_out, rdy_low drives ready low.
module hostbus_port #(
    parameter int AW     = hb_pkg::HB_AW,
    parameter int DW     = hb_pkg::HB_DW,
    parameter int STAGES = hb_pkg::HB_STAGES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mux_mode,
    input  logic          cs_n,
    input  logic          ale,
    input  logic          wr_n,
    input  logic          rd_n,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] dq_in,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe,
    output logic          rdy_low,
    output logic          reg_req,
    output logic          reg_we,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    input  logic [DW-1:0] reg_rdata,
    input  logic          reg_done
);
    localparam int          SW   = 4 + DW + AW;
    localparam logic [SW-1:0] SRST = {1'b1, 1'b0, 1'b1, 1'b1, {(DW+AW){1'b0}}};

    logic          s_cs_n, s_ale, s_wr_n, s_rd_n;
    logic [DW-1:0] s_dq;
    logic [AW-1:0] s_addr;
    logic          rd_evt, wr_evt;
    logic [AW-1:0] fall_addr, acc_addr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rd_buf;
    logic          rd_cmp, busy;
    logic          rd_served;
    logic          rd_hold;

    hb_sync #(.W(SW), .STAGES(STAGES), .RSTV(SRST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, ale, wr_n, rd_n, dq_in, addr_in}),
        .q     ({s_cs_n, s_ale, s_wr_n, s_rd_n, s_dq, s_addr})
    );

    hb_front #(.AW(AW), .DW(DW)) u_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .mux_mode  (mux_mode),
        .s_cs_n    (s_cs_n),
        .s_ale     (s_ale),
        .s_wr_n    (s_wr_n),
        .s_rd_n    (s_rd_n),
        .s_dq      (s_dq),
        .s_addr    (s_addr),
        .rd_evt    (rd_evt),
        .wr_evt    (wr_evt),
        .fall_addr (fall_addr),
        .acc_addr  (acc_addr),
        .wdata     (wdata)
    );

    hb_engine #(.AW(AW), .DW(DW)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_evt     (rd_evt),
        .wr_evt     (wr_evt),
        .rd_addr_in (fall_addr),
        .wr_addr_in (acc_addr),
        .wr_data_in (wdata),
        .reg_req    (reg_req),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .reg_done   (reg_done),
        .rd_buf     (rd_buf),
        .rd_cmp     (rd_cmp),
        .busy       (busy)
    );

    // marks that the current read strobe already has its data
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_served <= 1'b0;
        else if (s_rd_n) rd_served <= 1'b0;
        else if (rd_cmp) rd_served <= 1'b1;
    end

    assign rd_hold = !cs_n && !rd_n && !rd_served;
    assign rdy_low = busy || rd_hold;
    assign dq_oe   = !cs_n && !rd_n;
    assign dq_out  = rd_buf;

    // R7
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req |-> rdy_low);
endmodule

// File: tb/hostbus_port_test.sv
module hostbus_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mux_mode = 1'b1;
    logic       cs_n = 1'b1;
    logic       ale = 1'b0;
    logic       wr_n = 1'b1;
    logic       rd_n = 1'b1;
    logic [7:0] addr_in = 8'h00;
    logic [7:0] dq_in = 8'h00;
    logic [7:0] dq_out;
    logic       dq_oe, rdy_low, reg_req, reg_we;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic       reg_done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0] mem [256];
    logic [7:0] expv [256];
    int unsigned lat = 0;
    int unsigned cnt = 0;

    always #2.5 clk = ~clk;

    hostbus_port uut (
        .clk(clk), .rst_n(rst_n), .mux_mode(mux_mode), .cs_n(cs_n), .ale(ale),
        .wr_n(wr_n), .rd_n(rd_n), .addr_in(addr_in), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe), .rdy_low(rdy_low), .reg_req(reg_req),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_done(reg_done)
    );

    // register-side model with 0..7 cycle done latency
    assign reg_done  = reg_req && (cnt == lat);
    assign reg_rdata = mem[reg_addr];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
            cnt <= 0;
        end else if (reg_req) begin
            if (reg_done) begin
                if (reg_we) mem[reg_addr] <= reg_wdata;
                cnt <= 0;
                lat <= $urandom_range(0, 7);
            end else begin
                cnt <= cnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_ready(input string req);
        int t = 0;
        while (rdy_low && t < 60) begin
            cyc(1);
            t++;
        end
        chk(!rdy_low, req, rdy_low, 0);
    endtask

    // address phase on the lines the current mode uses
    task automatic addr_phase(input logic [7:0] a);
        if (mux_mode) dq_in = a; else addr_in = a;
        ale = 1'b1;
        cyc(3);
        ale = 1'b0;
        cyc(3);
    endtask

    task automatic strobe_wr(input logic [7:0] d, output bit rdy_seen);
        dq_in = d;
        wr_n = 1'b0;
        cyc(4);
        wr_n = 1'b1;
        rdy_seen = 0;
        for (int i = 0; i < 6; i++) begin
            cyc(1);
            if (rdy_low) rdy_seen = 1;
        end
    endtask

    task automatic strobe_rd(output logic [7:0] got, output bit hold_seen, output bit oe_ok);
        rd_n = 1'b0;
        cyc(1);
        hold_seen = rdy_low;
        wait_ready("R7");
        got = dq_out;
        oe_ok = dq_oe;
        rd_n = 1'b1;
        cyc(1);
        oe_ok = oe_ok && !dq_oe;
        cyc(4);
    endtask

    task automatic write_reg(input logic [7:0] a, input logic [7:0] d, input string req);
        bit seen;
        cs_n = 1'b0;
        cyc(2);
        addr_phase(a);
        strobe_wr(d, seen);
        cs_n = 1'b1;
        wait_ready(req);
        chk(seen, {req, " R7 write ready"}, seen, 1);
        expv[a] = d;
        cyc(3);
    endtask

    task automatic read_reg(input logic [7:0] a, input string req);
        logic [7:0] got;
        bit hold, oe;
        cs_n = 1'b0;
        cyc(2);
        addr_phase(a);
        strobe_rd(got, hold, oe);
        cs_n = 1'b1;
        cyc(3);
        chk(got == expv[a], req, got, expv[a]);
        chk(hold && oe, "R6 R7 oe/ready during read", {hold, oe}, 3);
    endtask

    task automatic t_reset;
        // R10
        chk(reg_req == 0, "R10 reg_req", reg_req, 0);
        chk(dq_oe == 0, "R10 dq_oe", dq_oe, 0);
        chk(rdy_low == 0, "R10 rdy_low", rdy_low, 0);
    endtask

    task automatic t_mux_basic;
        // R2 R5 R6
        mux_mode = 1'b1;
        write_reg(8'h12, 8'hA5, "R5 mux write");
        write_reg(8'h13, 8'h3C, "R5 mux write");
        read_reg(8'h12, "R2 mux read");
        read_reg(8'h13, "R2 mux read");
        read_reg(8'h14, "R6 untouched reg");
    endtask

    task automatic t_split_latched;
        // R3: latched split address wins over later addr_in
        bit seen;
        mux_mode = 1'b0;
        cs_n = 1'b0;
        cyc(2);
        addr_phase(8'h40);
        addr_in = 8'h41;
        strobe_wr(8'h77, seen);
        cs_n = 1'b1;
        wait_ready("R3");
        expv[8'h40] = 8'h77;
        cyc(3);
        read_reg(8'h40, "R3 latched split address");
        read_reg(8'h41, "R3 neighbour untouched");
    endtask

    task automatic t_split_direct;
        // R4: no latch pulse, address taken at strobe fall
        logic [7:0] got;
        bit seen, hold, oe;
        mux_mode = 1'b0;
        cs_n = 1'b0;
        addr_in = 8'h55;
        cyc(3);
        strobe_wr(8'hC3, seen);
        cs_n = 1'b1;
        wait_ready("R4");
        expv[8'h55] = 8'hC3;
        cyc(3);
        cs_n = 1'b0;
        addr_in = 8'h55;
        cyc(3);
        strobe_rd(got, hold, oe);
        cs_n = 1'b1;
        cyc(3);
        chk(got == 8'hC3, "R4 direct address", got, 8'hC3);
    endtask

    task automatic t_cs_ignore;
        // R1: strobes and latch ignored while deselected
        bit seen;
        mux_mode = 1'b1;
        cs_n = 1'b0;
        cyc(2);
        addr_phase(8'h20);
        cs_n = 1'b1;
        cyc(2);
        addr_phase(8'h21);
        strobe_wr(8'hEE, seen);
        chk(!seen, "R1 no ready while deselected", seen, 0);
        rd_n = 1'b0;
        cyc(2);
        chk(dq_oe == 0 && rdy_low == 0, "R1 read while deselected", {dq_oe, rdy_low}, 0);
        rd_n = 1'b1;
        cyc(5);
        cs_n = 1'b0;
        cyc(3);
        strobe_wr(8'h99, seen);
        cs_n = 1'b1;
        wait_ready("R1");
        expv[8'h20] = 8'h99;
        cyc(3);
        read_reg(8'h20, "R1 address kept from selected latch");
        read_reg(8'h21, "R1 deselected write ignored");
    endtask

    task automatic t_both_low;
        // R9: read wins, write discarded
        logic [7:0] got;
        bit hold, oe;
        mux_mode = 1'b1;
        cs_n = 1'b0;
        cyc(2);
        addr_phase(8'h30);
        dq_in = 8'h11;
        wr_n = 1'b0;
        cyc(2);
        strobe_rd(got, hold, oe);
        wr_n = 1'b1;
        cyc(6);
        cs_n = 1'b1;
        wait_ready("R9");
        cyc(3);
        chk(got == expv[8'h30], "R9 read serviced", got, expv[8'h30]);
        read_reg(8'h30, "R9 write discarded");
    endtask

    task automatic t_random;
        // R8: random latency, mixed modes
        for (int k = 0; k < 8; k++) begin
            logic [7:0] a = 8'($urandom_range(0, 255));
            logic [7:0] d = 8'($urandom_range(0, 255));
            mux_mode = k[0];
            write_reg(a, d, "R8 random write");
            read_reg(a, "R8 random read-back");
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) expv[i] = 8'(i) ^ 8'h5A;
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        cyc(3);
        t_mux_basic();
        t_split_latched();
        t_split_direct();
        t_cs_ignore();
        t_both_low();
        t_random();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule